// File: doc/BRIEF.md
# Configuration-Request Test Access Port

This block is the serial test and control port of a configuration memory device. A four-wire test clock interface (mode select, data in, data out, plus an optional synchronous reset) walks the standard sixteen-state test-port controller. Through it a host scans an 8-bit instruction, reads a fixed device identifier, reads a user-loadable code word, or passes data through a one-bit path. The capture value of the instruction register carries two live status bits from the device: whether in-system programming is active, and whether the read-protection flag is set.

One device-specific opcode asks an attached programmable device to reconfigure. When that opcode is latched, the event crosses from the test clock into the system clock domain on a toggle, and a counter there drives an active-low request line low for a fixed number of system clocks. The count is set from the clock frequency to give about 400 ns. Two further opcodes raise registered flags that tell the pin logic to float every output or to hold the outputs at their preset values.

Top module: `cfg_tap`

## Requirements
- R1: While `trst` is high at a rising `tck` edge, and at every rising `tck` edge in the Test-Logic-Reset state, the current instruction becomes the identifier opcode 8'hFE and both pin-control flags go low. After a system reset `cfg_req_n` is high.
- R2: Five rising `tck` edges in a row with `tms` high bring the controller to Test-Logic-Reset from any state. This is seen as `instr` reading 8'hFE.
- R3: In Capture-IR the instruction shift register loads {3'b000, isp_mode, sec_flag, 3'b001}, with bit 0 the first bit seen on `tdo`.
- R4: With the identifier opcode current, a data scan returns {ID_VER[3:0], 8'h50, ID_PART[7:0], 11'h049, 1'b1}, least significant bit first. The default is 32'h05006093.
- R5: The user-code opcode 8'hFD selects a 32-bit path. It captures `ucode_val` when `ucode_valid` is high and 32'hFFFFFFFF when it is low.
- R6: Every opcode other than 8'hFE and 8'hFD selects a one-bit path that captures 0. The input bit then appears on `tdo` one shift later.
- R7: At the rising edge that leaves Update-IR, `instr` takes the scanned opcode. Opcodes are 8'hFF pass-through, 8'h01 sample, 8'h00 external test, 8'hFA hold, 8'hFC float, 8'hFE identifier, 8'hFD user code and 8'hEE configuration request.
- R8: `pins_hiz` is high exactly when `instr` is 8'hFC. `pins_hold` is high exactly when `instr` is 8'hFA.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only during Shift-IR and Shift-DR.
- R10: Latching 8'hEE drives `cfg_req_n` low for exactly PULSE_NS*SYS_MHZ/1000 system clocks (80 by default). No other opcode moves it.
- R11: A further 8'hEE latched while a request pulse is low neither extends that pulse nor starts a second one. A later 8'hEE, latched once the line is high again, starts a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that times the request pulse |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test-port reset, sampled on `tck` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| isp_mode | input | 1 | Device is in programming mode |
| sec_flag | input | 1 | Read-protection flag |
| ucode_valid | input | 1 | A user code has been loaded |
| ucode_val | input | DR_W | Loaded user code |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for `tdo` |
| instr | output | 8 | Current instruction |
| pins_hiz | output | 1 | Float all device outputs |
| pins_hold | output | 1 | Hold outputs at their preset values |
| cfg_req_n | output | 1 | Active-low configuration request pulse |

## Verification
Two things can overlap here. A test-port scan can latch a new configuration request in the same window in which the system-domain counter is still timing an earlier pulse. The bench provokes this by latching the request opcode twice, about 300 ns apart, which is well inside the 400 ns pulse. A monitor on the system clock then measures every low stretch of `cfg_req_n`. The result passes only if exactly one stretch of exactly 80 clocks is seen, and a third request made after the line is high again gives one more pulse of the same width.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;
  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_t;

  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'hFA;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'hFC;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'hFE;
  localparam logic [IR_W-1:0] OP_UCODE  = 8'hFD;
  localparam logic [IR_W-1:0] OP_CONFIG = 8'hEE;
endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic    tck,
  input  logic    trst,
  input  logic    tms,
  output tap_st_t state
);
  tap_st_t nxt;

  always_comb begin
    unique case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= S_TLR;
    else      state <= nxt;
  end

  // checker: run of consecutive tms-high edges, saturating at 5
  logic [2:0] ones_run;
  always_ff @(posedge tck) begin
    if (trst)          ones_run <= 3'd0;
    else if (!tms)     ones_run <= 3'd0;
    else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
  end

  p_five_ones_r2: assert property (@(posedge tck) disable iff (trst)
    (ones_run == 3'd5) |-> (state == S_TLR));
endmodule

// File: rtl/cfg_tap_regs.sv
module cfg_tap_regs
  import cfg_tap_pkg::*;
#(
  parameter int           DR_W    = 32,
  parameter logic [3:0]   ID_VER  = 4'h0,
  parameter logic [7:0]   ID_PART = 8'h06
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tdi,
  input  tap_st_t         state,
  input  logic            isp_mode,
  input  logic            sec_flag,
  input  logic            ucode_valid,
  input  logic [DR_W-1:0] ucode_val,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [IR_W-1:0] instr,
  output logic            pins_hiz,
  output logic            pins_hold,
  output logic            cfg_tog
);
  localparam logic [31:0]     ID_WORD = {ID_VER, 8'h50, ID_PART, 11'h049, 1'b1};
  localparam logic [DR_W-1:0] ALL_ONE = '1;

  logic [IR_W-1:0] ir_sr;
  logic [DR_W-1:0] dr_sr;
  logic            wide_sel;
  logic [IR_W-1:0] ir_cap;

  assign wide_sel = (instr == OP_IDCODE) || (instr == OP_UCODE);
  assign ir_cap   = {{(IR_W-5){1'b0}}, isp_mode, sec_flag, 3'b001};

  // instruction path
  always_ff @(posedge tck) begin
    if (trst) begin
      ir_sr     <= '0;
      instr     <= OP_IDCODE;
      pins_hiz  <= 1'b0;
      pins_hold <= 1'b0;
      cfg_tog   <= 1'b0;
    end else begin
      case (state)
        S_TLR: begin
          instr     <= OP_IDCODE;
          pins_hiz  <= 1'b0;
          pins_hold <= 1'b0;
        end
        S_CAP_IR: ir_sr <= ir_cap;
        S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        S_UPD_IR: begin
          instr     <= ir_sr;
          pins_hiz  <= (ir_sr == OP_HIGHZ);
          pins_hold <= (ir_sr == OP_CLAMP);
          if (ir_sr == OP_CONFIG) cfg_tog <= ~cfg_tog;
        end
        default: ;
      endcase
    end
  end

  // data path: 32-bit identifier / user code or one-bit pass-through
  always_ff @(posedge tck) begin
    if (trst) begin
      dr_sr <= '0;
    end else if (state == S_CAP_DR) begin
      if (instr == OP_IDCODE)     dr_sr <= DR_W'(ID_WORD);
      else if (instr == OP_UCODE) dr_sr <= ucode_valid ? ucode_val : ALL_ONE;
      else                        dr_sr <= '0;
    end else if (state == S_SH_DR) begin
      if (wide_sel) dr_sr    <= {tdi, dr_sr[DR_W-1:1]};
      else          dr_sr[0] <= tdi;
    end
  end

  // output stage on the falling edge
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == S_SH_IR) || (state == S_SH_DR);
      tdo    <= (state == S_SH_IR) ? ir_sr[0] :
                (state == S_SH_DR) ? dr_sr[0] : 1'b0;
    end
  end

  p_cap_pattern_r3: assert property (@(posedge tck) disable iff (trst)
    (state == S_CAP_IR) |=> (ir_sr == {{(IR_W-5){1'b0}}, $past(isp_mode), $past(sec_flag), 3'b001}));
  p_tlr_instr_r1: assert property (@(posedge tck) disable iff (trst)
    (state == S_TLR) |=> (instr == OP_IDCODE && !pins_hiz && !pins_hold));
  p_oe_shift_r9: assert property (@(posedge tck) disable iff (trst)
    tdo_oe |-> (state == S_SH_IR || state == S_SH_DR));
  p_flags_r8: assert property (@(posedge tck) disable iff (trst)
    (pins_hiz == (instr == OP_HIGHZ)) && (pins_hold == (instr == OP_CLAMP)));
endmodule

// File: rtl/cfg_tap_pulse.sv
module cfg_tap_pulse #(
  parameter int SYS_MHZ     = 200,
  parameter int PULSE_NS    = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_tog,
  output logic cfg_req_n
);
  localparam int PULSE_CYC = (PULSE_NS * SYS_MHZ) / 1000;
  localparam int CW        = $clog2(PULSE_CYC + 1);

  logic [SYNC_STAGES:0] sync;
  logic [CW-1:0]        cnt;
  logic                 start;

  generate
    for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)         sync[i] <= 1'b0;
        else if (i == 0) sync[i] <= req_tog;
        else             sync[i] <= sync[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign start = sync[SYNC_STAGES] ^ sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cfg_req_n <= 1'b1;
    end else if (start && cfg_req_n) begin
      cnt       <= CW'(PULSE_CYC - 1);
      cfg_req_n <= 1'b0;
    end else if (cnt != '0) begin
      cnt       <= cnt - 1'b1;
    end else begin
      cfg_req_n <= 1'b1;
    end
  end

  // checker: length of the current low stretch
  logic [CW:0] low_len;
  always_ff @(posedge clk) begin
    if (rst)             low_len <= '0;
    else if (!cfg_req_n) low_len <= low_len + 1'b1;
    else                 low_len <= '0;
  end

  p_pulse_width_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_n) |-> (low_len == (CW+1)'(PULSE_CYC)));
  p_no_overlong_r11: assert property (@(posedge clk) disable iff (rst)
    (low_len <= (CW+1)'(PULSE_CYC)));
endmodule

// File: rtl/cfg_tap.sv
module cfg_tap
  import cfg_tap_pkg::*;
#(
  parameter int         DR_W        = 32,
  parameter logic [3:0] ID_VER      = 4'h0,
  parameter logic [7:0] ID_PART     = 8'h06,
  parameter int         SYS_MHZ     = 200,
  parameter int         PULSE_NS    = 400,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            sys_clk,
  input  logic            sys_rst,
  input  logic            tck,
  input  logic            trst,
  input  logic            tms,
  input  logic            tdi,
  input  logic            isp_mode,
  input  logic            sec_flag,
  input  logic            ucode_valid,
  input  logic [DR_W-1:0] ucode_val,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [7:0]      instr,
  output logic            pins_hiz,
  output logic            pins_hold,
  output logic            cfg_req_n
);
  tap_st_t state;
  logic    cfg_tog;

  cfg_tap_fsm u_fsm (
    .tck(tck), .trst(trst), .tms(tms), .state(state)
  );

  cfg_tap_regs #(.DR_W(DR_W), .ID_VER(ID_VER), .ID_PART(ID_PART)) u_regs (
    .tck(tck), .trst(trst), .tdi(tdi), .state(state),
    .isp_mode(isp_mode), .sec_flag(sec_flag),
    .ucode_valid(ucode_valid), .ucode_val(ucode_val),
    .tdo(tdo), .tdo_oe(tdo_oe), .instr(instr),
    .pins_hiz(pins_hiz), .pins_hold(pins_hold), .cfg_tog(cfg_tog)
  );

  cfg_tap_pulse #(.SYS_MHZ(SYS_MHZ), .PULSE_NS(PULSE_NS), .SYNC_STAGES(SYNC_STAGES)) u_pulse (
    .clk(sys_clk), .rst(sys_rst), .req_tog(cfg_tog), .cfg_req_n(cfg_req_n)
  );
endmodule

// File: tb/cfg_tap_test.sv
`timescale 1ns/1ps
module cfg_tap_test;
  localparam int PULSE_CYC = 80;

  logic sys_clk = 0, tck = 0;
  logic sys_rst = 1, trst = 1, tms = 1, tdi = 0;
  logic isp_mode = 0, sec_flag = 0, ucode_valid = 0;
  logic [31:0] ucode_val = 32'h0;
  logic tdo, tdo_oe, pins_hiz, pins_hold, cfg_req_n;
  logic [7:0] instr;

  always #2.5 sys_clk = ~sys_clk;
  always #10  tck = ~tck;

  cfg_tap uut (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .tck(tck), .trst(trst),
    .tms(tms), .tdi(tdi), .isp_mode(isp_mode), .sec_flag(sec_flag),
    .ucode_valid(ucode_valid), .ucode_val(ucode_val),
    .tdo(tdo), .tdo_oe(tdo_oe), .instr(instr),
    .pins_hiz(pins_hiz), .pins_hold(pins_hold), .cfg_req_n(cfg_req_n)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t exp_q[$];
  logic [31:0] obs_q[$];
  int pulse_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare scanned words against expected items
  initial forever begin
    wait (obs_q.size() > 0);
    begin
      logic [31:0] o;
      item_t e;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      chk(o == e.val, e.tag, o, e.val);
    end
  end

  // pulse monitor on the system clock
  initial begin
    int len;
    len = 0;
    forever begin
      @(negedge sys_clk);
      if (!sys_rst) begin
        if (cfg_req_n === 1'b0) len++;
        else if (len > 0) begin pulse_q.push_back(len); len = 0; end
      end
    end
  end

  task automatic tick(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck); #2;
    o = tdo; e = tdo_oe; tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    logic o, e;
    for (int i = 0; i < n; i++) tick(0, 0, o, e);
  endtask

  // shift n bits from the shift state, leave in Run-Test/Idle after update
  task automatic shift_n(input int n, input logic [31:0] d, output logic [31:0] got, output bit oe_all);
    logic o, e;
    got = '0; oe_all = 1;
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, d[i], o, e);
      got[i] = o;
      if (!e) oe_all = 0;
    end
    tick(1, 0, o, e);   // Exit1 -> Update
    tick(0, 0, o, e);   // Update -> RTI
    tick(0, 0, o, e);   // idle, update has taken effect
  endtask

  task automatic scan_ir(input logic [7:0] op, input string tag);
    logic o, e;
    logic [31:0] got;
    bit oe_all;
    tick(1, 0, o, e); tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    exp_q.push_back('{tag, {24'h0, 3'b000, isp_mode, sec_flag, 3'b001}});
    shift_n(8, {24'h0, op}, got, oe_all);
    obs_q.push_back(got);
    chk(oe_all, "R9 tdo_oe high in Shift-IR", oe_all, 1);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] d, input logic [31:0] exp, input string tag);
    logic o, e;
    logic [31:0] got;
    bit oe_all;
    tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    exp_q.push_back('{tag, exp});
    shift_n(n, d, got, oe_all);
    obs_q.push_back(got);
  endtask

  task automatic finish_run();
    wait (obs_q.size() == 0);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic o, e;
    repeat (4) @(negedge tck);
    trst = 0; sys_rst = 0;
    #2;
    // R1 reset state
    chk(instr == 8'hFE, "R1 instr after reset", instr, 8'hFE);
    chk(cfg_req_n == 1, "R1 cfg_req_n after reset", cfg_req_n, 1);
    chk(!pins_hiz && !pins_hold, "R1 pin flags after reset", {pins_hiz, pins_hold}, 0);
    idle(2);
    tick(0, 0, o, e);
    chk(e == 0, "R9 tdo_oe low in Run-Test/Idle", e, 0);

    // R4 identifier straight after reset
    scan_dr(32, 32'h0, 32'h05006093, "R4 identifier word");

    // R3 capture pattern with live status bits
    isp_mode = 1; sec_flag = 0;
    scan_ir(8'hFD, "R3 capture isp=1 sec=0");
    chk(instr == 8'hFD, "R7 instr user code", instr, 8'hFD);
    // R5 user code not loaded
    ucode_valid = 0;
    scan_dr(32, 32'h0, 32'hFFFFFFFF, "R5 user code blank");
    ucode_valid = 1; ucode_val = 32'hA5C3_1234;
    scan_dr(32, 32'h0, 32'hA5C3_1234, "R5 user code loaded");

    isp_mode = 0; sec_flag = 1;
    scan_ir(8'hFF, "R3 capture isp=0 sec=1");
    chk(instr == 8'hFF, "R7 instr pass-through", instr, 8'hFF);
    // R6 one-bit path
    scan_dr(8, 32'h0000_00B6, {24'h0, 8'h6C}, "R6 pass-through delay");
    scan_ir(8'h5A, "R3 capture before unlisted op");
    scan_dr(8, 32'h0000_0093, {24'h0, 8'h26}, "R6 unlisted opcode one-bit path");

    // R8 pin-control flags
    scan_ir(8'hFC, "R3 capture before float");
    chk(pins_hiz && !pins_hold, "R8 float flag", {pins_hiz, pins_hold}, 2'b10);
    scan_ir(8'hFA, "R3 capture before hold");
    chk(!pins_hiz && pins_hold, "R8 hold flag", {pins_hiz, pins_hold}, 2'b01);
    scan_ir(8'h01, "R3 capture before sample");
    chk(!pins_hiz && !pins_hold, "R8 flags clear on sample", {pins_hiz, pins_hold}, 0);

    // R2 five tms-high edges from Shift-DR reach reset state
    tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    for (int i = 0; i < 6; i++) tick(1, 0, o, e);
    tick(0, 0, o, e);
    chk(instr == 8'hFE, "R2 five tms-high to reset state", instr, 8'hFE);
    idle(2);

    // R10 no pulse from other opcodes so far
    #600;
    chk(pulse_q.size() == 0, "R10 no pulse from other opcodes", pulse_q.size(), 0);

    // R10 single request
    scan_ir(8'hEE, "R3 capture before config");
    #800;
    chk(pulse_q.size() == 1, "R10 one pulse", pulse_q.size(), 1);
    if (pulse_q.size() > 0) begin
      int w;
      w = pulse_q.pop_front();
      chk(w == PULSE_CYC, "R10 pulse width", w, PULSE_CYC);
    end

    // R11 second request while low is ignored
    pulse_q.delete();
    scan_ir(8'hEE, "R3 capture before config A");
    scan_ir(8'hEE, "R3 capture before config B");
    #800;
    chk(pulse_q.size() == 1, "R11 overlapping request single pulse", pulse_q.size(), 1);
    if (pulse_q.size() > 0) begin
      int w;
      w = pulse_q.pop_front();
      chk(w == PULSE_CYC, "R11 width not extended", w, PULSE_CYC);
    end
    pulse_q.delete();
    scan_ir(8'hEE, "R3 capture before config C");
    #800;
    chk(pulse_q.size() == 1, "R11 later request pulses again", pulse_q.size(), 1);

    // R1 trst returns instruction to identifier
    @(negedge tck); trst = 1; @(negedge tck); @(negedge tck); trst = 0; #2;
    chk(instr == 8'hFE, "R1 instr after trst", instr, 8'hFE);

    finish_run();
  end
endmodule